// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A small shift register records whether each of the most recent resolved branches was taken. Its value is joined with a few low-order bits of the branch address. Together they pick one saturating counter, and the top bit of that counter is the guess. The same branch address therefore has a separate counter for every possible recent-history pattern. A branch whose direction follows from its neighbours' outcomes can then be predicted correctly when a per-address table alone would keep failing.

The fetch side presents an instruction address and gets a combinational taken/not-taken answer in the same cycle. It also sees the history value in use, and it keeps that value with the branch. When the branch resolves, the pipeline returns the address, the real outcome and that saved history value. Only the counter chosen at prediction time is trained, and the outcome is then shifted into the history register. There is no tag compare, so branches whose index bits match share counters. With a history length of zero the block becomes a plain per-address table of counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken), so every lookup predicts not taken, and the history register reads all zeros.
- R2: The lookup is combinational. `lkTaken` is the top bit of the counter selected by {history register, `lkPc[IDX_BITS+1:2]`}, where 1 means taken, and it changes with `lkPc` without waiting for a clock edge.
- R3: On a cycle with `updValid` high, the history register shifts left one place, `updTaken` enters bit 0 and the oldest bit is dropped. On any cycle with `updValid` low the register holds its value.
- R4: A counter saturates. Training taken at 2'b11 leaves it at 2'b11, and training not taken at 2'b00 leaves it at 2'b00.
- R5: A counter steps by exactly one per update, up for taken and down for not taken. From a strong state, two contrary outcomes are needed to flip the prediction.
- R6: An update changes only the counter at {`updHist`, `updPc[IDX_BITS+1:2]`}. The counters for the same address under other history values are left unchanged.
- R7: The counter that is trained is selected by the supplied `updHist` snapshot, not by the current content of the history register.
- R8: Address bits [1:0] and all bits above the index field are ignored. Addresses that agree in bits [IDX_BITS+1:2] share counters.
- R9: With HIST_BITS = 0 the block is a per-address table. `curHist` reads 0, `updHist` is ignored, and the prediction depends only on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkPc | input | PC_W | Fetch address to predict |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| curHist | output | max(HIST_BITS,1) | History value used by the current lookup |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updHist | input | max(HIST_BITS,1) | History snapshot saved at prediction time |

## Verification
The embedded properties check on every cycle that the history register shifts in the real outcome and holds when no update arrives. They also check that a trained counter moves by exactly one step, that it sticks at either end, and that the control never raises increment and decrement together. The bench's scenarios are needed to show the effects that span several updates. These are the choice of counter through the saved history rather than the live register, the untouched counters of other histories, address aliasing, the two-miss hysteresis as seen from the prediction output, and the collapse to a per-address table when the history length is zero.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;
  // Strobes from the training control to the counter/history datapath
  typedef struct packed {
    logic ctrUp;      // increment selected counter
    logic ctrDn;      // decrement selected counter
    logic histShift;  // shift resolved outcome into history
  } trainStrb_t;
endpackage

// File: rtl/corr_bpred_ctrl.sv
module corr_bpred_ctrl
  import corr_bpred_pkg::*;
#(
  parameter int CTR_BITS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [CTR_BITS-1:0] updCtr,
  output trainStrb_t          strb
);
  localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
  localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

  logic atTop, atBot;
  assign atTop = (updCtr == CTR_MAX);
  assign atBot = (updCtr == CTR_MIN);

  always_comb begin
    strb           = '0;
    strb.histShift = updValid;
    strb.ctrUp     = updValid &&  updTaken && !atTop;
    strb.ctrDn     = updValid && !updTaken && !atBot;
  end

  // R5: a counter never moves in both directions at once
  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrUp, strb.ctrDn}));

  // R6: no counter moves without a resolved branch
  p_train_needs_upd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrUp || strb.ctrDn) |-> updValid);
endmodule

// File: rtl/corr_bpred_dp.sv
module corr_bpred_dp
  import corr_bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2,
  parameter int IDX_BITS  = 4,
  parameter int CTR_BITS  = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PC_W-1:0]     lkPc,
  input  logic [PC_W-1:0]     updPc,
  input  logic [HW-1:0]       updHist,
  input  logic                updTaken,
  input  trainStrb_t          strb,
  output logic                lkTaken,
  output logic [HW-1:0]       curHist,
  output logic [CTR_BITS-1:0] updCtr
);
  localparam int TAB_BITS = HIST_BITS + IDX_BITS;
  localparam int ENTRIES  = 1 << TAB_BITS;
  localparam logic [CTR_BITS-1:0] CTR_RST = CTR_BITS'(1) << (CTR_BITS - 2);
  localparam logic [CTR_BITS-1:0] CTR_MAX = '1;
  localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

  logic [CTR_BITS-1:0] ctrTab [ENTRIES];
  logic [TAB_BITS-1:0] lkIdx, uIdx;
  logic [IDX_BITS-1:0] lkAddr, uAddr;

  assign lkAddr = lkPc[IDX_BITS+1:2];
  assign uAddr  = updPc[IDX_BITS+1:2];

  logic unusedBits;
  assign unusedBits = ^{lkPc[PC_W-1:IDX_BITS+2], lkPc[1:0],
                        updPc[PC_W-1:IDX_BITS+2], updPc[1:0], updHist};

  generate
    if (HIST_BITS == 0) begin : g_nohist
      assign lkIdx   = lkAddr;
      assign uIdx    = uAddr;
      assign curHist = '0;
    end else begin : g_hist
      logic [HIST_BITS-1:0] ghr;
      if (HIST_BITS == 1) begin : g_one
        always_ff @(posedge clk) begin
          if (!rstN)               ghr <= '0;
          else if (strb.histShift) ghr <= updTaken;
        end
      end else begin : g_many
        always_ff @(posedge clk) begin
          if (!rstN)               ghr <= '0;
          else if (strb.histShift) ghr <= {ghr[HIST_BITS-2:0], updTaken};
        end
      end
      assign lkIdx   = {ghr, lkAddr};
      assign uIdx    = {updHist, uAddr};
      assign curHist = ghr;

      // R3: newest outcome lands in bit 0
      p_hist_in_r3: assert property (@(posedge clk) disable iff (!rstN)
        strb.histShift |=> ghr[0] == $past(updTaken));
      // R3: history idle without an update
      p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
        !strb.histShift |=> $stable(ghr));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ctrTab[i] <= CTR_RST;
    end else if (strb.ctrUp) begin
      ctrTab[uIdx] <= ctrTab[uIdx] + 1'b1;
    end else if (strb.ctrDn) begin
      ctrTab[uIdx] <= ctrTab[uIdx] - 1'b1;
    end
  end

  assign lkTaken = ctrTab[lkIdx][CTR_BITS-1];
  assign updCtr  = ctrTab[uIdx];

  // R4: saturation at the top
  p_sat_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.histShift && updTaken && updCtr == CTR_MAX)
      |=> ctrTab[$past(uIdx)] == CTR_MAX);
  // R4: saturation at the bottom
  p_sat_bot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.histShift && !updTaken && updCtr == CTR_MIN)
      |=> ctrTab[$past(uIdx)] == CTR_MIN);
  // R5: single step up
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.histShift && updTaken && updCtr != CTR_MAX)
      |=> ctrTab[$past(uIdx)] == $past(updCtr) + 1'b1);
  // R5: single step down
  p_step_dn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.histShift && !updTaken && updCtr != CTR_MIN)
      |=> ctrTab[$past(uIdx)] == $past(updCtr) - 1'b1);
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import corr_bpred_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_BITS = 2,
  parameter int IDX_BITS  = 4,
  parameter int CTR_BITS  = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lkPc,
  output logic            lkTaken,
  output logic [HW-1:0]   curHist,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [HW-1:0]   updHist
);
  trainStrb_t          strb;
  logic [CTR_BITS-1:0] updCtr;

  corr_bpred_ctrl #(.CTR_BITS(CTR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
    .updCtr(updCtr), .strb(strb)
  );

  corr_bpred_dp #(
    .PC_W(PC_W), .HIST_BITS(HIST_BITS), .IDX_BITS(IDX_BITS), .CTR_BITS(CTR_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .updPc(updPc), .updHist(updHist),
    .updTaken(updTaken), .strb(strb), .lkTaken(lkTaken), .curHist(curHist),
    .updCtr(updCtr)
  );
endmodule

// File: tb/sim_corr_bpred.sv
`timescale 1ns/1ps
module sim_corr_bpred;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // default instance: 2 history bits, 4 index bits
  logic [31:0] lkPc = '0, updPc = '0;
  logic        lkTaken, updValid = 1'b0, updTaken = 1'b0;
  logic [1:0]  curHist, updHist = '0;

  corr_bpred u0 (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkTaken(lkTaken), .curHist(curHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updHist(updHist)
  );

  // zero-history instance
  logic [31:0] zLkPc = '0, zUpdPc = '0;
  logic        zLkTaken, zUpdValid = 1'b0, zUpdTaken = 1'b0;
  logic [0:0]  zCurHist, zUpdHist = 1'b1;

  corr_bpred #(.HIST_BITS(0)) u1 (
    .clk(clk), .rstN(rstN), .lkPc(zLkPc), .lkTaken(zLkTaken), .curHist(zCurHist),
    .updValid(zUpdValid), .updPc(zUpdPc), .updTaken(zUpdTaken), .updHist(zUpdHist)
  );

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [1:0] h, input logic t);
    @(negedge clk);
    updPc = pc; updHist = h; updTaken = t; updValid = 1'b1;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic zUpd(input logic t);
    @(negedge clk);
    zUpdPc = 32'h10C; zUpdTaken = t; zUpdValid = 1'b1;
    @(negedge clk);
    zUpdValid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc);
    lkPc = pc;
    #0.5;
  endtask

  // {taken, updHist[1:0], expected prediction for 0x100, expected history[1:0]}
  localparam logic [5:0] VEC [12] = '{
    6'b1_00_0_01,  // R3 shift in, R6 other history still weak
    6'b1_01_0_11,
    6'b1_11_1_11,  // R2 prediction from trained counter
    6'b1_11_1_11,
    6'b1_11_1_11,  // R4 top saturation
    6'b0_11_0_10,
    6'b0_10_1_00,  // R6 counter of history 00 kept its taken state
    6'b0_00_0_00,
    6'b0_00_0_00,
    6'b0_00_0_00,  // R4 bottom saturation
    6'b1_00_1_01,
    6'b0_01_0_10
  };

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    nChk++; nFail++;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    look(32'h100); chk("R1 pred A", lkTaken, 0);
    look(32'h104); chk("R1 pred B", lkTaken, 0);
    chk("R1 history", curHist, 0);
    zLkPc = 32'h10C; #0.5;
    chk("R1 zero-hist pred", zLkTaken, 0);

    // vector table walk on address 0x100
    foreach (VEC[i]) begin
      upd(32'h100, VEC[i][4:3], VEC[i][5]);
      look(32'h100);
      chk("R2 R5 table pred", lkTaken, VEC[i][2]);
      chk("R3 table history", curHist, VEC[i][1:0]);
    end

    // history now 10; R7: train 0x108 through snapshot 01
    upd(32'h108, 2'b01, 1'b1);
    look(32'h108);
    chk("R7 snapshot selects counter", lkTaken, 1);
    chk("R3 history after snapshot update", curHist, 2'b01);

    // R6: history back to 10, counter of 0x108 under 10 untouched
    upd(32'h104, 2'b01, 1'b0);
    look(32'h108);
    chk("R6 other history counter unchanged", lkTaken, 0);
    chk("R3 history 10", curHist, 2'b10);

    // R8: train an alias of 0x108 under history 10, return history to 10
    upd(32'h14A, 2'b10, 1'b1);
    upd(32'h104, 2'b01, 1'b0);
    look(32'h109);
    chk("R8 alias low bits", lkTaken, 1);
    look(32'h108);
    chk("R8 alias upper bits", lkTaken, 1);

    // R3 hold with no updates; R2 combinational switch of address
    repeat (5) @(negedge clk);
    chk("R3 history holds", curHist, 2'b10);
    look(32'h100);
    chk("R2 lookup follows address", lkTaken, 0);

    // R9, R4, R5 on the zero-history instance (updHist tied to 1)
    zUpd(1'b1); #0.5; chk("R9 per-address train", zLkTaken, 1);
    chk("R9 history reads zero", zCurHist, 0);
    zUpd(1'b1);
    zUpd(1'b1);
    zUpd(1'b0); #0.5; chk("R4 R5 top sat then one miss", zLkTaken, 1);
    zUpd(1'b0); #0.5; chk("R5 second miss flips", zLkTaken, 0);
    zUpd(1'b0);
    zUpd(1'b0);
    zUpd(1'b1); #0.5; chk("R4 bottom sat then one hit", zLkTaken, 0);
    zUpd(1'b1); #0.5; chk("R5 second hit flips", zLkTaken, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule